// File: doc/BRIEF.md
# Random Allocation Tag Generator

This block picks a 4-bit allocation tag for a memory-tagging pointer scheme and writes it into a 64-bit pointer. It holds two pieces of state: a 16-bit linear feedback shift register (LFSR) seed and a 4-bit start tag. A random request advances the LFSR four times to produce a pseudo-random offset. A walk over the sixteen tag values then turns that offset into a tag, stepping past every tag whose bit is set in an exclusion mask.

An explicit request takes its start tag from the incoming pointer and uses an offset supplied with the request. A global exclusion mask, `cfg_excl`, applies to both request types. A random request also ORs in its own per-request mask.

Requests use a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low while a walk is in progress, and the caller holds its request until it is accepted. Results come back as a one-cycle `res_valid` pulse and cannot be stalled, so the consumer must capture the result in that cycle.

Top module: `alloc_tag_gen`

## Requirements
- R1: When the effective exclusion mask is 16'hFFFF, the result tag is 0, whatever the seed, the start tag or the offset.
- R2: With offset 0, the result is the first non-excluded tag found by counting upward modulo 16 from the start tag. The start tag itself is a candidate.
- R3: With a non-zero offset N, the walk moves N times. Each move advances by at least one modulo 16, then keeps advancing past excluded tags. The result is the tag where the last move ends.
- R4: One LFSR step forms the XOR of seed bits 5, 3, 2 and 0, shifts the seed right by one and places that XOR at bit 15. A random offset uses four steps, and step i supplies offset bit i (step 0 gives the LSB).
- R5: A random request stores the chosen tag as the new start tag and stores the seed advanced by four steps. An explicit request changes neither.
- R6: A random request uses `req_excl | cfg_excl` as its mask. An explicit request uses `cfg_excl` only, and its `req_excl` has no effect on the result.
- R7: An explicit request takes its start tag from `req_ptr[59:56]` and its offset from `req_offset`.
- R8: `res_ptr` equals the accepted pointer with bits [59:56] replaced by `res_tag`. All other bits are unchanged.
- R9: `res_valid` is high for exactly one cycle per request. The pulse comes max(1, N) cycles after acceptance, or 1 cycle when the mask is all ones. `busy` is high and `req_ready` is low from acceptance until the pulse.
- R10: `req_mode` = 0 selects a random request and `req_mode` = 1 selects an explicit request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_excl | input | 16 | Global exclusion mask; bit t excludes tag t |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_mode | input | 1 | 0 random, 1 explicit |
| req_ptr | input | 64 | Pointer to tag |
| req_excl | input | 16 | Per-request exclusion mask (random requests only) |
| req_offset | input | 4 | Offset for explicit requests |
| busy | output | 1 | Walk in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_tag | output | 4 | Chosen tag |
| res_ptr | output | 64 | Pointer with tag inserted |

## Verification
The bench targets the following corner cases:

- **All-ones mask.** A design that still walks here would return a non-zero tag or take N cycles instead of one.
- **Offset 0 on an excluded start.** A wrong design either returns the excluded start tag or skips a valid start tag.
- **Wrap-around.** The bench walks from tag 15 to 0, and runs offset 15 against a mask with a single permitted tag. An off-by-one or unwrapped counter lands on the wrong tag there.
- **LFSR state.** Random requests are chained and interleaved with explicit ones. A wrong tap, wrong shift direction or wrong offset bit order, or state updated on explicit requests, makes later random tags drift from the model.
- **Latency.** The bench checks the cycle of each result, which exposes the random offset directly.

// File: rtl/alloc_tag_pkg.sv
package alloc_tag_pkg;
  typedef enum logic {
    MODE_RAND = 1'b0,
    MODE_EXPL = 1'b1
  } tag_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walk_state_e;
endpackage

// File: rtl/tag_lfsr_step.sv
// Advances the seed STEPS times; the feedback bit of step i is offset bit i.
module tag_lfsr_step #(
  parameter int SEED_W = 16,
  parameter int STEPS  = 4
) (
  input  logic [SEED_W-1:0] seed,
  output logic [STEPS-1:0]  offset,
  output logic [SEED_W-1:0] seed_adv
);
  always_comb begin
    logic [SEED_W-1:0] s;
    logic fb;
    s = seed;
    offset = '0;
    for (int i = 0; i < STEPS; i++) begin
      fb = s[5] ^ s[3] ^ s[2] ^ s[0];
      s = {fb, s[SEED_W-1:1]};
      offset[i] = fb;
    end
    seed_adv = s;
  end
endmodule

// File: rtl/tag_seek.sv
// Finds the first non-excluded tag at or after cur (incl=1) or strictly after cur (incl=0), modulo 2**TAG_W.
module tag_seek #(
  parameter int TAG_W = 4
) (
  input  logic [TAG_W-1:0]        cur,
  input  logic [(1<<TAG_W)-1:0]   mask,
  input  logic                    incl,
  output logic [TAG_W-1:0]        found
);
  localparam int NTAG = 1 << TAG_W;

  always_comb begin
    logic [TAG_W-1:0] bump;
    logic [TAG_W-1:0] cand;
    bump  = incl ? '0 : TAG_W'(1);
    found = cur;
    // descending scan so the nearest candidate is written last
    for (int k = NTAG - 1; k >= 0; k--) begin
      cand = cur + TAG_W'(k) + bump;
      if (!mask[cand]) found = cand;
    end
  end
endmodule

// File: rtl/alloc_tag_gen.sv
module alloc_tag_gen
  import alloc_tag_pkg::*;
#(
  parameter int              PTR_W      = 64,
  parameter int              TAG_W      = 4,
  parameter int              TAG_LSB    = 56,
  parameter int              SEED_W     = 16,
  parameter logic [15:0]     SEED_INIT  = 16'hACE1,
  parameter logic [3:0]      START_INIT = 4'h0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [(1<<TAG_W)-1:0]   cfg_excl,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_mode,
  input  logic [PTR_W-1:0]        req_ptr,
  input  logic [(1<<TAG_W)-1:0]   req_excl,
  input  logic [TAG_W-1:0]        req_offset,
  output logic                    busy,
  output logic                    res_valid,
  output logic [TAG_W-1:0]        res_tag,
  output logic [PTR_W-1:0]        res_ptr
);
  localparam int NTAG = 1 << TAG_W;
  localparam logic [PTR_W-1:0] TAG_FIELD =
    {{(PTR_W-TAG_W){1'b0}}, {TAG_W{1'b1}}} << TAG_LSB;

  walk_state_e       st_q;
  tag_mode_e         mode_q;
  logic [SEED_W-1:0] seed_q;
  logic [TAG_W-1:0]  start_q;
  logic [TAG_W-1:0]  cur_q;
  logic [TAG_W-1:0]  rem_q;
  logic              zero_q;
  logic [NTAG-1:0]   mask_q;
  logic [PTR_W-1:0]  ptr_q;

  logic [TAG_W-1:0]  rnd_off;
  logic [SEED_W-1:0] seed_adv;
  logic [TAG_W-1:0]  seek_tag;
  logic              accept;
  logic              all_excl;
  logic              finish;
  logic [TAG_W-1:0]  tag_d;
  logic [PTR_W-1:0]  ptr_d;

  tag_lfsr_step #(.SEED_W(SEED_W), .STEPS(TAG_W)) u_lfsr (
    .seed     (seed_q),
    .offset   (rnd_off),
    .seed_adv (seed_adv)
  );

  tag_seek #(.TAG_W(TAG_W)) u_seek (
    .cur   (cur_q),
    .mask  (mask_q),
    .incl  (zero_q),
    .found (seek_tag)
  );

  assign busy      = (st_q == ST_WALK);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign all_excl  = &mask_q;
  assign finish    = all_excl || zero_q || (rem_q == TAG_W'(1));
  assign tag_d     = all_excl ? '0 : seek_tag;

  always_comb begin
    ptr_d = ptr_q;
    ptr_d[TAG_LSB +: TAG_W] = tag_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      mode_q    <= MODE_RAND;
      seed_q    <= SEED_W'(SEED_INIT);
      start_q   <= TAG_W'(START_INIT);
      cur_q     <= '0;
      rem_q     <= '0;
      zero_q    <= 1'b0;
      mask_q    <= '0;
      ptr_q     <= '0;
      res_valid <= 1'b0;
      res_tag   <= '0;
      res_ptr   <= '0;
    end else begin
      res_valid <= 1'b0;
      if (accept) begin
        st_q   <= ST_WALK;
        mode_q <= tag_mode_e'(req_mode);
        ptr_q  <= req_ptr;
        if (tag_mode_e'(req_mode) == MODE_RAND) begin
          mask_q <= req_excl | cfg_excl;
          cur_q  <= start_q;
          rem_q  <= rnd_off;
          zero_q <= (rnd_off == '0);
        end else begin
          mask_q <= cfg_excl;
          cur_q  <= req_ptr[TAG_LSB +: TAG_W];
          rem_q  <= req_offset;
          zero_q <= (req_offset == '0);
        end
      end else if (st_q == ST_WALK) begin
        if (finish) begin
          st_q      <= ST_IDLE;
          res_valid <= 1'b1;
          res_tag   <= tag_d;
          res_ptr   <= ptr_d;
          if (mode_q == MODE_RAND) begin
            start_q <= tag_d;
            seed_q  <= seed_adv;
          end
        end else begin
          cur_q <= seek_tag;
          rem_q <= rem_q - TAG_W'(1);
        end
      end
    end
  end

  // R1: a fully excluded mask always yields tag zero
  p_allones_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && all_excl) |-> (res_tag == '0));

  // R2: any result under a partly open mask is a permitted tag
  p_tag_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !all_excl) |-> !mask_q[res_tag]);

  // R3: each offset move lands on a permitted tag
  p_seek_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !zero_q && !all_excl) |-> !mask_q[seek_tag]);

  // R5: the seed changes only when a random request completes
  p_seed_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(seed_q) |-> (res_valid && mode_q == MODE_RAND));

  // R8: only the tag field of the pointer is rewritten
  p_ptr_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (((res_ptr ^ ptr_q) & ~TAG_FIELD) == '0
                   && res_ptr[TAG_LSB +: TAG_W] == res_tag));

  // R9: result strobe lasts one cycle
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R9: an accepted request makes the block busy next cycle
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !req_ready));
endmodule

// File: tb/alloc_tag_gen_tb_top.sv
module alloc_tag_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_excl = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_mode = 1'b0;
  logic [63:0] req_ptr = '0;
  logic [15:0] req_excl = '0;
  logic [3:0]  req_offset = '0;
  logic        busy;
  logic        res_valid;
  logic [3:0]  res_tag;
  logic [63:0] res_ptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  alloc_tag_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_excl(cfg_excl),
    .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
    .req_ptr(req_ptr), .req_excl(req_excl), .req_offset(req_offset),
    .busy(busy), .res_valid(res_valid), .res_tag(res_tag), .res_ptr(res_ptr)
  );

  typedef struct {
    logic [3:0]  tag;
    logic [63:0] ptr;
    int          due;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;
  logic [15:0] m_seed = 16'hACE1;
  logic [3:0]  m_start = 4'h0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] m_choose(input logic [3:0] t, input int off,
                                          input logic [15:0] ex);
    if (ex == 16'hFFFF) return 4'h0;
    if (off == 0) begin
      while (ex[t]) t = t + 4'h1;
    end else begin
      do begin
        do t = t + 4'h1; while (ex[t]);
        off--;
      end while (off > 0);
    end
    return t;
  endfunction

  task automatic do_req(input bit mode, input logic [63:0] ptr,
                        input logic [15:0] ex, input logic [3:0] off,
                        input string req);
    exp_t e;
    logic [15:0] eff;
    logic [3:0] st;
    int o;
    while (!req_ready) @(negedge clk);
    if (mode == 1'b0) begin
      logic [15:0] s;
      logic fb;
      s = m_seed;
      o = 0;
      for (int i = 0; i < 4; i++) begin
        fb = s[5] ^ s[3] ^ s[2] ^ s[0];
        s = {fb, s[15:1]};
        o = o | (int'(fb) << i);
      end
      eff = ex | cfg_excl;
      st = m_start;
      e.tag = m_choose(st, o, eff);
      m_start = e.tag;
      m_seed = s;
    end else begin
      eff = cfg_excl;
      o = int'(off);
      e.tag = m_choose(ptr[59:56], o, eff);
    end
    e.ptr = ptr;
    e.ptr[59:56] = e.tag;
    e.due = cyc + 1 + (((eff == 16'hFFFF) || o == 0) ? 1 : o);
    e.req = req;
    exp_q.push_back(e);
    req_valid = 1'b1; req_mode = mode; req_ptr = ptr;
    req_excl = ex; req_offset = off;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy && !req_ready, "R9", "busy after accept", {busy, req_ready}, 2'b10);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor / scoreboard
  logic prev_valid = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid && prev_valid)
        check(1'b0, "R9", "pulse width", 2, 1);
      if (res_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R9", "unexpected result", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(res_tag == e.tag, e.req, "tag", res_tag, e.tag);
          check(res_ptr == e.ptr, "R8", "pointer", res_ptr, e.ptr);
          check(cyc == e.due, "R9", "latency cycle", cyc, e.due);
        end
      end
    end
    prev_valid = res_valid;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && req_ready && !res_valid, "R9", "reset state",
          {busy, req_ready, res_valid}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 R4: random requests, open masks
    do_req(1'b0, 64'h0F00_1234_5678_9ABC, 16'h0000, 4'h0, "R4");
    do_req(1'b0, 64'hF0A5_0000_DEAD_BEEF, 16'h00F0, 4'h0, "R4");
    // R6: global mask combined with request mask
    cfg_excl = 16'h0A0A;
    do_req(1'b0, 64'h1111_2222_3333_4444, 16'h5050, 4'h0, "R6");
    // R1: all ones through the combination
    do_req(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 16'hF5F5, 4'h9, "R1");
    // R2 R7: explicit, excluded start skips upward; req_excl ignored (R6)
    cfg_excl = 16'h0020;
    do_req(1'b1, 64'h0500_0000_0000_0010, 16'hFFFF, 4'h0, "R6");
    do_req(1'b1, 64'h0300_0000_0000_0020, 16'h0000, 4'h0, "R2");
    // R3: explicit non-zero offset skipping 6 and 7
    cfg_excl = 16'h00C0;
    do_req(1'b1, 64'h7500_ABCD_0000_0030, 16'h0000, 4'h3, "R3");
    // R3: wrap with a single permitted tag
    cfg_excl = ~16'h0008;
    do_req(1'b1, 64'h0C00_0000_0000_0040, 16'h0000, 4'hF, "R3");
    // R3: wrap 15 -> 0
    cfg_excl = 16'h0000;
    do_req(1'b1, 64'h8F00_0000_0000_0050, 16'h0000, 4'h1, "R3");
    // R1: explicit all ones
    cfg_excl = 16'hFFFF;
    do_req(1'b1, 64'h0A00_0000_0000_0060, 16'h0000, 4'h7, "R1");
    // R5: random after explicit requests continues the model state
    cfg_excl = 16'h0000;
    for (int i = 0; i < 8; i++)
      do_req(1'b0, 64'h0000_1000_0000_0000 + 64'(i), 16'(1 << i), 4'h0, "R5");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule